// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Identity Loader

This block fetches a short identity record once after reset from a three-wire serial EEPROM. The memory's data-in and data-out pins are tied together, so the block shares one data wire in both directions. The block generates the serial clock and drives the read command and the start address. It then lets go of the data wire and shifts in three consecutive 16-bit words. The memory steps through the addresses on its own, so the block sends only one address.

From those words it keeps a vendor identifier, a product identifier and a ganged power-switching bit. When the last bit has been captured, the block raises `done`, drops chip select and turns off its drivers on the clock and data pins. Other logic can then use the memory. A strap input can skip the read altogether. In that case fixed default identifiers are used, and the ganged bit is taken straight from the shared data pin, which then serves as a mode strap.

Top module: `eeprom_id_loader`

## Requirements
- R1: While `rst_n` is low, `done`, `cs_o`, `sk_o`, `sk_oe` and `dio_oe` are all 0.
- R2: With `skip_rom` high, `done` is 1 one clock after reset is released. `vid` and `pid` then equal the parameters `DEF_VID` and `DEF_PID`, and the serial clock never pulses.
- R3: With `skip_rom` high, `ganged` equals the current level of `dio_i` and follows every change of it.
- R4: With `skip_rom` low, the first nine serial-clock rising edges each see `dio_oe`=1 and `dio_o` stable. In order they carry 1, 1, 0 and then the six address bits 000000, most significant bit first (the start bit, then read opcode 10, then the address).
- R5: The serial clock has a period of `CLK_DIV` system clocks, rising edge to rising edge, with 58 rising edges in one read: 9 command bits, 1 dummy bit and 48 data bits.
- R6: From the tenth serial-clock period on, `dio_oe` is 0. The block samples `dio_i` when the serial clock falls. The memory changes the data on rising edges.
- R7: The 49 bits received are one dummy bit followed by words W0, W1 and W2, each sent most significant bit first. At `done`, `vid`=W1, `pid`=W2 and `ganged`=W0 bit 15.
- R8: Once `done` is 1 it stays 1 until reset. `cs_o`, `sk_oe` and `dio_oe` are 0, the serial clock produces no further edges, and `vid`/`pid` do not change.
- R9: `pulldown_en` is 1 exactly when `skip_rom` is 0.
- R10: `cs_o` is 1 from the first command bit through the last data bit, and `sk_o` is high only while `cs_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| skip_rom | input | 1 | Strap: 1 skips the read and uses the defaults |
| dio_i | input | 1 | Level seen on the shared data pin |
| sk_o | output | 1 | Serial clock to the memory |
| sk_oe | output | 1 | Drive enable for the serial clock pin |
| cs_o | output | 1 | Memory chip select, active high |
| dio_o | output | 1 | Data value driven toward the memory |
| dio_oe | output | 1 | Drive enable for the shared data pin |
| pulldown_en | output | 1 | Enables the weak pulldowns on the clock and data pins |
| vid | output | 16 | Vendor identifier |
| pid | output | 16 | Product identifier |
| ganged | output | 1 | Ganged power-switching mode bit |
| done | output | 1 | Load is complete |

## Verification
The assertions take for granted that `skip_rom` is a static strap that does not move while reset is high. They also assume that `dio_i` is driven by the memory only once the block has released the wire. The bench writes `skip_rom` only while reset is held low. Its memory model drives the wire only from serial-clock rising edges after the ninth, and otherwise returns the strap level. The identity values are read back through the output ports, not from internal state. The scoreboard queues the expected identifiers before each reset is released and compares them when `done` rises.

// File: rtl/idl_pkg.sv
// Package: shared types for the EEPROM identity loader.
// Assumes: nothing beyond IEEE 1800-2017.
package idl_pkg;
    // Sequencer states: waiting after reset, serial transfer, finished.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } idl_state_t;
endpackage

// File: rtl/idl_clkdiv.sv
// Module: idl_clkdiv
// Makes the serial clock from the system clock while 'run' is high.
// Each serial period starts low for DIV/2 cycles and ends high for the rest.
// 'fall_tick' marks the system cycle whose closing edge drops the clock.
// Assumes: DIV is even and at least 2.
module idl_clkdiv #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sk,
    output logic fall_tick
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    // Phase counter: wraps every DIV cycles and holds at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (!run)                    cnt <= '0;
        else if (cnt == CW'(DIV - 1))     cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    // Clock level and the end-of-period marker.
    always_comb begin
        sk        = run && (cnt >= CW'(HALF));
        fall_tick = run && (cnt == CW'(DIV - 1));
    end
endmodule

// File: rtl/idl_seq.sv
// Module: idl_seq
// Sequencer for the one-shot read. It leaves idle once after reset, going
// either to done (strap set) or into the transfer. In the transfer it counts
// serial periods, stepping at each serial-clock fall.
// Assumes: 'skip' is stable from reset release.
module idl_seq
    import idl_pkg::*;
#(
    parameter int TOTAL = 58,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          skip,
    input  logic          fall_tick,
    output idl_state_t    state,
    output logic [IW-1:0] bit_idx,
    output logic          finish,
    output logic          take_default
);
    logic last_bit;

    // Decode of the final period's closing edge and of the strap path.
    always_comb begin
        last_bit     = (bit_idx == IW'(TOTAL - 1));
        finish       = (state == ST_XFER) && fall_tick && last_bit;
        take_default = (state == ST_IDLE) && skip;
    end

    // State register: one pass through IDLE per reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: state <= skip ? ST_DONE : ST_XFER;
                ST_XFER: if (finish) state <= ST_DONE;
                default: state <= ST_DONE;
            endcase
        end
    end

    // Period counter: steps at each serial-clock fall during the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  bit_idx <= '0;
        else if (state == ST_XFER && fall_tick && !last_bit)
                                                     bit_idx <= bit_idx + 1'b1;
    end
endmodule

// File: rtl/idl_rxshift.sv
// Module: idl_rxshift
// Input shift register for the bits returned by the memory. It shifts
// most-significant-first on 'shift_en' and presents the value it will hold
// after the shift, so the caller can capture on the same edge.
// Assumes: 'din' is stable at the sampling edge.
module idl_rxshift #(
    parameter int W = 49
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] next_q
);
    logic [W-1:0] q;

    // Value after including the current input bit.
    always_comb next_q = {q[W-2:0], din};

    // Shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= next_q;
    end
endmodule

// File: rtl/eeprom_id_loader.sv
// Module: eeprom_id_loader (top)
// Reads one identity record from a three-wire serial EEPROM whose data pins
// share a single wire. The command is a start bit, opcode 10 and the
// address. The record is one dummy bit then N_WORDS words. Word 0 bit 15
// is the ganged bit, word 1 the vendor id, word 2 the product id.
// Assumes: the memory advances its address on its own and changes its
// output on the serial clock's rising edge. 'skip_rom' is a static strap.
module eeprom_id_loader
    import idl_pkg::*;
#(
    parameter int          CLK_DIV  = 8,
    parameter int          ADDR_W   = 6,
    parameter int          ROM_ADDR = 0,
    parameter int          WORD_W   = 16,
    parameter int          N_WORDS  = 3,
    parameter logic [15:0] DEF_VID  = 16'h1A2B,
    parameter logic [15:0] DEF_PID  = 16'h3C4D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        skip_rom,
    input  logic        dio_i,
    output logic        sk_o,
    output logic        sk_oe,
    output logic        cs_o,
    output logic        dio_o,
    output logic        dio_oe,
    output logic        pulldown_en,
    output logic [15:0] vid,
    output logic [15:0] pid,
    output logic        ganged,
    output logic        done
);
    localparam int CMD_BITS = 3 + ADDR_W;
    localparam int RX_BITS  = 1 + N_WORDS * WORD_W;
    localparam int TOTAL    = CMD_BITS + RX_BITS;
    localparam int IW       = $clog2(TOTAL);
    localparam logic [CMD_BITS-1:0] CMD_WORD = {1'b1, 2'b10, ADDR_W'(ROM_ADDR)};

    idl_state_t          state;
    logic [IW-1:0]       bit_idx;
    logic                finish, take_default, fall_tick, run, rx_en;
    logic [RX_BITS-1:0]  rx_next;
    logic [CMD_BITS-1:0] cmd_shift;
    logic [WORD_W-1:0]   word [N_WORDS];
    logic [15:0]         vid_q, pid_q;
    logic                gang_q;

    idl_seq #(.TOTAL(TOTAL), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .skip(skip_rom), .fall_tick(fall_tick),
        .state(state), .bit_idx(bit_idx), .finish(finish),
        .take_default(take_default)
    );

    idl_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .sk(sk_o), .fall_tick(fall_tick)
    );

    idl_rxshift #(.W(RX_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(rx_en), .din(dio_i), .next_q(rx_next)
    );

    // Split the received record into words, word 0 arriving first.
    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
        assign word[gi] = rx_next[(N_WORDS-1-gi)*WORD_W +: WORD_W];
    end

    // Pin control: the hub drives data only during the command periods.
    always_comb begin
        run         = (state == ST_XFER);
        cs_o        = run;
        sk_oe       = run;
        dio_oe      = run && (bit_idx < IW'(CMD_BITS));
        cmd_shift   = CMD_WORD << bit_idx;
        dio_o       = dio_oe && cmd_shift[CMD_BITS-1];
        rx_en       = run && fall_tick && (bit_idx >= IW'(CMD_BITS));
        pulldown_en = !skip_rom;
        done        = (state == ST_DONE);
    end

    // Identity registers: defaults on the strap path, record words at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_q  <= '0;
            pid_q  <= '0;
            gang_q <= 1'b0;
        end else if (take_default) begin
            vid_q  <= DEF_VID;
            pid_q  <= DEF_PID;
        end else if (finish) begin
            vid_q  <= 16'(word[1]);
            pid_q  <= 16'(word[2]);
            gang_q <= word[0][WORD_W-1];
        end
    end

    // Output view: the ganged bit comes from the pin when the read is skipped.
    always_comb begin
        vid    = vid_q;
        pid    = pid_q;
        ganged = skip_rom ? dio_i : gang_q;
    end
endmodule

// File: rtl/idl_checker.sv
// Module: idl_checker
// Temporal checks on the loader's pins, attached by bind.
// Assumes: skip_rom changes only while rst_n is low.
module idl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        skip_rom,
    input logic        sk_o,
    input logic        sk_oe,
    input logic        cs_o,
    input logic        dio_o,
    input logic        dio_oe,
    input logic        done,
    input logic [15:0] vid,
    input logic [15:0] pid
);
    // R4: an outgoing bit is already settled when the serial clock rises.
    a_r4_bit_settled: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sk_o) && dio_oe) |-> $stable(dio_o));

    // R6: the turnaround happens inside the transaction, not at its end.
    a_r6_release_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dio_oe) |-> cs_o);

    // R10: no serial clock pulse without chip select.
    a_r10_sk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);

    // R8: finished means every pin is released.
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cs_o && !sk_oe && !dio_oe && !sk_o));

    // R8: done is held until the next reset.
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8: identifiers are frozen once loaded.
    a_r8_ids_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(vid) && $stable(pid)));

    // R2: the strap path never opens a transaction.
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        skip_rom |-> (!cs_o && !sk_oe));
endmodule

bind eeprom_id_loader idl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .skip_rom(skip_rom), .sk_o(sk_o),
    .sk_oe(sk_oe), .cs_o(cs_o), .dio_o(dio_o), .dio_oe(dio_oe),
    .done(done), .vid(vid), .pid(pid)
);

// File: tb/tb_eeprom_id_loader.sv
`timescale 1ns/1ps
// Scoreboard bench: run_case queues the expected identity, the monitor
// compares it when done rises, and a memory model answers the serial read.
module tb_eeprom_id_loader;
    localparam int DIV = 8;

    logic        clk = 0, rst_n = 0, skip_rom = 0, pin_lvl = 0, drv = 0;
    logic        sk_o, sk_oe, cs_o, dio_o, dio_oe, pulldown_en, ganged, done;
    logic [15:0] vid, pid;
    logic [15:0] w0, w1, w2;
    logic        dio_i;
    int          total = 0, bad = 0;
    logic [48:0] q_exp [$];

    // Memory model state, cleared by reset.
    int         rise_cnt, oe_err, per_err, cs_err, cyc, last_rise;
    logic [8:0] cmd_bits;
    logic       sk_prev, done_prev;

    always #2.5 clk = ~clk;

    assign dio_i = cs_o ? drv : pin_lvl;

    eeprom_id_loader dut (
        .clk(clk), .rst_n(rst_n), .skip_rom(skip_rom), .dio_i(dio_i),
        .sk_o(sk_o), .sk_oe(sk_oe), .cs_o(cs_o), .dio_o(dio_o), .dio_oe(dio_oe),
        .pulldown_en(pulldown_en), .vid(vid), .pid(pid), .ganged(ganged),
        .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Memory model: captures command bits and returns data on rising edges.
    always @(posedge sk_o or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt <= 0; oe_err <= 0; cs_err <= 0; cmd_bits <= '0; drv <= 1'b0;
        end else begin
            if (!cs_o) cs_err <= cs_err + 1;
            if (rise_cnt < 9) begin
                cmd_bits <= {cmd_bits[7:0], dio_o};
                if (!dio_oe) oe_err <= oe_err + 1;
            end else begin
                if (dio_oe) oe_err <= oe_err + 1;
                drv <= ({1'b0, w0, w1, w2} >> (48 - (rise_cnt - 9))) & 49'd1;
            end
            rise_cnt <= rise_cnt + 1;
        end
    end

    // Monitor: serial clock spacing (R5) and scoreboard compare on done.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            per_err = 0; last_rise = -1; sk_prev = 0; done_prev = 0;
        end else begin
            if (sk_o && !sk_prev) begin
                if (last_rise >= 0 && cyc - last_rise != DIV) per_err++;
                last_rise = cyc;
            end
            sk_prev = sk_o;
            if (done && !done_prev) begin
                if (q_exp.size() == 0) check(0, "R7 unexpected done", 0, 1);
                else begin
                    logic [48:0] e;
                    e = q_exp.pop_front();
                    check({vid, pid, ganged} == 33'(e), "R7/R2 identity",
                          {vid, pid, ganged}, 33'(e));
                end
            end
            done_prev = done;
        end
    end

    task automatic run_case(input logic skip, input logic [15:0] a, b, c,
                            input logic pin);
        int waited;
        rst_n = 0;
        @(negedge clk);
        skip_rom = skip; pin_lvl = pin; w0 = a; w1 = b; w2 = c;
        if (skip) q_exp.push_back({16'h0, 16'h1A2B, 16'h3C4D, pin});
        else      q_exp.push_back({16'h0, b, c, a[15]});
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !cs_o && !sk_o && !sk_oe && !dio_oe, "R1 reset outputs",
              {done, cs_o, sk_o, sk_oe, dio_oe}, 0);
        rst_n = 1;
        @(negedge clk);
        if (skip) check(done == 1, "R2 done one clock after reset", done, 1);
        waited = 0;
        while (!done && waited < 2000) begin @(negedge clk); waited++; end
        check(done == 1, "R8 done reached", done, 1);
        repeat (3 * DIV) @(negedge clk);
        check(pulldown_en == !skip, "R9 pulldown", pulldown_en, !skip);
        check(!cs_o && !sk_oe && !dio_oe && done, "R8 pins released",
              {cs_o, sk_oe, dio_oe, done}, 1);
        if (skip) begin
            check(rise_cnt == 0, "R2 no serial clock", rise_cnt, 0);
            check(ganged == pin, "R3 ganged from pin", ganged, pin);
            pin_lvl = !pin; #1;
            check(ganged == !pin, "R3 ganged follows pin", ganged, !pin);
        end else begin
            check(cmd_bits == 9'b110000000, "R4 command bits", cmd_bits, 9'b110000000);
            check(rise_cnt == 58, "R5 rising edge count", rise_cnt, 58);
            check(per_err == 0, "R5 serial period", per_err, 0);
            check(oe_err == 0, "R6 drive turnaround", oe_err, 0);
            check(cs_err == 0, "R10 chip select span", cs_err, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run_case(0, 16'h8000, 16'h1234, 16'hABCD, 0);
        run_case(0, 16'h0000, 16'hFFFF, 16'h0001, 1);
        run_case(0, 16'h8000, 16'h5AA5, 16'hC33C, 0);
        run_case(1, 16'h0000, 16'h0000, 16'h0000, 1);
        run_case(1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
        run_case(0, 16'h0000, 16'h0F0F, 16'hF0F0, 1);
        check(q_exp.size() == 0, "R7 scoreboard drained", q_exp.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule